// File: doc/BRIEF.md
# Tournament Local/Global Branch Direction Predictor

This block predicts whether a conditional branch will be taken by running two direction predictors side by side and letting a third table decide which one to trust. The local component keeps a small bank of per-branch history registers, picked by low bits of the branch address. The chosen register's contents index a table of 2-bit saturating counters. The global component keeps a single shift register of recent outcomes from all branches, and that register indexes a second counter table. A chooser table, also indexed by the global history, holds 2-bit counters that learn, entry by entry, which component has been more accurate.

A lookup is purely combinational. The fetch logic presents a branch address and gets back the final direction, the two component directions and the chooser's decision. When the branch resolves, the pipeline presents the address, the real outcome and the two component predictions it saved at lookup time. Both component tables and both histories are then trained, and the chooser is trained if the components disagreed. The model assumes each branch resolves before the next lookup, so an update indexes with the history values current at that edge. A context-switch input returns every table and history register to its initial state.

Top module: `tour_predictor`

## Requirements
- R1: After reset, every direction counter is 2'b10 (weakly taken), every chooser counter is 2'b01 (weakly favouring local) and every history register is zero. A lookup at any address therefore reports local = 1, global = 1, use_global = 0 and final = 1.
- R2: The local prediction is bit 1 of the local counter whose index is the local history register selected by lk_pc[LSEL_W-1:0].
- R3: The global prediction is bit 1 of the global counter indexed by the global history register.
- R4: The final prediction equals the global prediction when bit 1 of the chooser counter indexed by the global history is set (reported on lk_use_global). Otherwise it equals the local prediction.
- R5: Every valid update steps the addressed local and global counters one step toward the outcome (taken = up), saturating at 2'b00 and 2'b11. The index is the history value before this update's shift.
- R6: A valid update shifts the outcome into the lsb of the global history and of the one local history register selected by upd_pc. Every other history register holds its value.
- R7: The chooser counter at the current global history steps up when only the global component was correct and down when only the local component was correct. It is unchanged when both saved predictions agree.
- R8: ctx_clear restores the R1 state on the next edge and overrides an update in the same cycle.
- R9: A lookup made in the same cycle as an update returns the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctx_clear | input | 1 | Context switch: clear all state |
| lk_pc | input | PC_W | Lookup branch address |
| lk_pred | output | 1 | Final predicted direction (1 = taken) |
| lk_local_pred | output | 1 | Local component direction |
| lk_global_pred | output | 1 | Global component direction |
| lk_use_global | output | 1 | Chooser selects global component |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | PC_W | Resolved branch address |
| upd_taken | input | 1 | Resolved outcome |
| upd_local_pred | input | 1 | Local prediction saved at lookup |
| upd_global_pred | input | 1 | Global prediction saved at lookup |

## Verification
The lookup and the training update fall in the same cycle on every resolved branch in the bench. The branch's own address is presented on the lookup port while its update is pending, and the outputs are judged against a model state that has not yet absorbed that update. The second collision is ctx_clear arriving together with a valid update. It is provoked after a long training run, and afterwards every address must look up as the freshly reset state. Long local loops, alternating patterns and a pseudo-random address/outcome stream drive both counter saturation and chooser disagreement.

// File: rtl/tour_pkg.sv
package tour_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_TAKEN = 2'b10;
  localparam ctr2_t CTR_WEAK_LOCAL = 2'b01;

  // saturating one-step move of a 2-bit counter
  function automatic ctr2_t sat_step(ctr2_t c, logic up);
    if (up) return (c == 2'b11) ? c : ctr2_t'(c + 2'd1);
    else    return (c == 2'b00) ? c : ctr2_t'(c - 2'd1);
  endfunction

  // direction carried by a counter
  function automatic logic ctr_dir(ctr2_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tour_pkg::*;
#(
  parameter int    IDX_W = 4,
  parameter ctr2_t INIT  = CTR_WEAK_TAKEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t cnt_q [DEPTH];
  ctr2_t wr_cur;

  assign wr_cur = cnt_q[wr_idx];
  assign rd_cnt = cnt_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= INIT;
    end else if (clr) begin
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= INIT;
    end else if (wr_en) begin
      cnt_q[wr_idx] <= sat_step(wr_cur, wr_up);
    end
  end

  // R5: saturation at the top
  p_sat_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && wr_up && wr_cur == 2'b11) |=> cnt_q[$past(wr_idx)] == 2'b11);
  // R5: saturation at the bottom
  p_sat_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && !wr_up && wr_cur == 2'b00) |=> cnt_q[$past(wr_idx)] == 2'b00);
  // R7: no write leaves the entry untouched
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> cnt_q[$past(wr_idx)] == $past(wr_cur));
  // R8: clear restores the initial value
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q[0] == INIT && cnt_q[DEPTH-1] == INIT));
endmodule

// File: rtl/tp_hist_bank.sv
module tp_hist_bank #(
  parameter int SEL_W  = 3,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist
);
  localparam int NREG = 1 << SEL_W;

  logic [HIST_W-1:0] hist_q [NREG];

  assign rd_hist = hist_q[rd_sel];
  assign wr_hist = hist_q[wr_sel];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  hist_q[g] <= '0;
        else if (clr)                                hist_q[g] <= '0;
        else if (wr_en && wr_sel == SEL_W'(g))       hist_q[g] <= {hist_q[g][HIST_W-2:0], wr_bit};
      end
    end
  endgenerate

  // R6: the selected register takes the outcome in its lsb
  p_shift_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> hist_q[$past(wr_sel)][0] == $past(wr_bit));
  // R6: the old low bits move up one place
  p_shift_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> hist_q[$past(wr_sel)][HIST_W-1:1] == $past(wr_hist[HIST_W-2:0]));
endmodule

// File: rtl/tour_predictor.sv
module tour_predictor
  import tour_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int LSEL_W  = 3,
  parameter int LHIST_W = 4,
  parameter int GHIST_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctx_clear,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  output logic            lk_local_pred,
  output logic            lk_global_pred,
  output logic            lk_use_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local_pred,
  input  logic            upd_global_pred
);
  logic [LSEL_W-1:0]  lk_sel, upd_sel;
  logic [LHIST_W-1:0] lk_lhist, upd_lhist;
  logic [GHIST_W-1:0] ghr_q;
  ctr2_t              lk_lcnt, lk_gcnt, lk_ccnt;

  // named internal events
  logic train;         // a valid resolved branch trains the tables
  logic comp_disagree; // exactly one component was correct
  logic global_won;    // the global component was the correct one

  assign lk_sel        = lk_pc[LSEL_W-1:0];
  assign upd_sel       = upd_pc[LSEL_W-1:0];
  assign train         = upd_valid && !ctx_clear;
  assign comp_disagree = upd_local_pred != upd_global_pred;
  assign global_won    = upd_global_pred == upd_taken;

  tp_hist_bank #(.SEL_W(LSEL_W), .HIST_W(LHIST_W)) u_lhist (
    .clk(clk), .rst_n(rst_n), .clr(ctx_clear),
    .rd_sel(lk_sel), .rd_hist(lk_lhist),
    .wr_en(upd_valid), .wr_sel(upd_sel), .wr_bit(upd_taken), .wr_hist(upd_lhist)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_WEAK_TAKEN)) u_local (
    .clk(clk), .rst_n(rst_n), .clr(ctx_clear),
    .rd_idx(lk_lhist), .rd_cnt(lk_lcnt),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_TAKEN)) u_global (
    .clk(clk), .rst_n(rst_n), .clr(ctx_clear),
    .rd_idx(ghr_q), .rd_cnt(lk_gcnt),
    .wr_en(upd_valid), .wr_idx(ghr_q), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_LOCAL)) u_chooser (
    .clk(clk), .rst_n(rst_n), .clr(ctx_clear),
    .rd_idx(ghr_q), .rd_cnt(lk_ccnt),
    .wr_en(upd_valid && comp_disagree), .wr_idx(ghr_q), .wr_up(global_won)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ghr_q <= '0;
    else if (ctx_clear) ghr_q <= '0;
    else if (upd_valid) ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken};
  end

  assign lk_local_pred  = ctr_dir(lk_lcnt);
  assign lk_global_pred = ctr_dir(lk_gcnt);
  assign lk_use_global  = ctr_dir(lk_ccnt);
  assign lk_pred        = lk_use_global ? lk_global_pred : lk_local_pred;

  // R4: when the components agree the choice is irrelevant
  p_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_local_pred == lk_global_pred) |-> lk_pred == lk_local_pred);
  // R6: global history holds without an update
  p_ghr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !ctx_clear) |=> $stable(ghr_q));
  // R6: global history takes the outcome in its lsb
  p_ghr_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    train |=> ghr_q[0] == $past(upd_taken));
  // R8: clear wins over a same-cycle update
  p_clear_ghr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clear |=> ghr_q == '0);
endmodule

// File: tb/test_tour_predictor.sv
module test_tour_predictor;
  localparam int PC_W = 8, LSEL_W = 3, LHIST_W = 4, GHIST_W = 4;
  localparam int NLOC = 1 << LSEL_W, NL = 1 << LHIST_W, NG = 1 << GHIST_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic            rst_n, ctx_clear, upd_valid, upd_taken, upd_local_pred, upd_global_pred;
  logic [PC_W-1:0] lk_pc, upd_pc;
  logic            lk_pred, lk_local_pred, lk_global_pred, lk_use_global;

  tour_predictor #(.PC_W(PC_W), .LSEL_W(LSEL_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)) i_tour_predictor (
    .clk(clk), .rst_n(rst_n), .ctx_clear(ctx_clear), .lk_pc(lk_pc),
    .lk_pred(lk_pred), .lk_local_pred(lk_local_pred), .lk_global_pred(lk_global_pred),
    .lk_use_global(lk_use_global), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_local_pred(upd_local_pred), .upd_global_pred(upd_global_pred)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench-side state of the requirements
  int m_lpht [NL];
  int m_gpht [NG];
  int m_ch   [NG];
  int m_lhr  [NLOC];
  int m_ghr;

  function automatic int step(int c, bit up);
    if (up) return (c >= 3) ? 3 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  task automatic m_reset();
    foreach (m_lpht[i]) m_lpht[i] = 2;
    foreach (m_gpht[i]) m_gpht[i] = 2;
    foreach (m_ch[i])   m_ch[i]   = 1;
    foreach (m_lhr[i])  m_lhr[i]  = 0;
    m_ghr = 0;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // compare all lookup outputs for pc against the bench state
  task automatic cmp_lookup(int pc, string tl, string tg, string tf, string tu);
    int lh; bit el, eg, eu;
    lh = m_lhr[pc % NLOC];
    el = m_lpht[lh] >= 2;
    eg = m_gpht[m_ghr] >= 2;
    eu = m_ch[m_ghr] >= 2;
    chk(tl, lk_local_pred, el);
    chk(tg, lk_global_pred, eg);
    chk(tu, lk_use_global, eu);
    chk(tf, lk_pred, eu ? eg : el);
  endtask

  task automatic look(int pc, string tag);
    @(negedge clk);
    upd_valid = 1'b0;
    lk_pc = PC_W'(pc);
    #1;
    cmp_lookup(pc, tag, tag, tag, tag);
  endtask

  // lookup + resolve in the same cycle; lookup must see pre-update state
  task automatic branch(int pc, bit taken);
    int sel, lh, gh; bit el, eg;
    @(negedge clk);
    sel = pc % NLOC; lh = m_lhr[sel]; gh = m_ghr;
    el = m_lpht[lh] >= 2; eg = m_gpht[gh] >= 2;
    lk_pc = PC_W'(pc); upd_pc = PC_W'(pc); upd_taken = taken;
    upd_local_pred = el; upd_global_pred = eg; upd_valid = 1'b1;
    #1;
    cmp_lookup(pc, "R2,R5,R6 local", "R3,R5,R6 global", "R4,R9 final", "R7 chooser");
    @(posedge clk);
    m_lpht[lh] = step(m_lpht[lh], taken);
    m_gpht[gh] = step(m_gpht[gh], taken);
    if (el != eg) m_ch[gh] = step(m_ch[gh], eg == taken);
    m_lhr[sel] = ((lh << 1) | int'(taken)) % NL;
    m_ghr = ((gh << 1) | int'(taken)) % NG;
    #1 upd_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    rst_n = 1'b0; ctx_clear = 1'b0; upd_valid = 1'b0; upd_taken = 1'b0;
    upd_local_pred = 1'b0; upd_global_pred = 1'b0; lk_pc = '0; upd_pc = '0;
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state at every local history register
    for (int p = 0; p < NLOC; p++) look(p, "R1 reset");

    // local loop pattern, three taken then one not taken, per address
    for (int it = 0; it < 6; it++)
      for (int p = 0; p < NLOC; p++)
        for (int k = 0; k < 4; k++) branch(p, k != 3);

    // alternating global pattern across two addresses
    for (int it = 0; it < 40; it++) begin
      branch(3, it[0]);
      branch(5, !it[0]);
    end

    // long not-taken run to reach bottom saturation (R5)
    for (int it = 0; it < 10; it++) branch(6, 1'b0);
    look(6, "R5 saturate low");
    for (int it = 0; it < 10; it++) branch(6, 1'b1);
    look(6, "R5 saturate high");

    // pseudo-random stream
    lfsr = 16'hACE1;
    for (int it = 0; it < 600; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      branch(int'(lfsr[7:0]), lfsr[9] | (lfsr[8] & lfsr[3]));
    end

    // R6: only the selected local register moved; look at all of them
    for (int p = 0; p < NLOC; p++) look(p, "R6 idle lookup");

    // R8: clear together with an update
    @(negedge clk);
    ctx_clear = 1'b1; upd_valid = 1'b1; upd_pc = 8'd2; upd_taken = 1'b0;
    upd_local_pred = 1'b1; upd_global_pred = 1'b0;
    @(posedge clk);
    #1 ctx_clear = 1'b0; upd_valid = 1'b0;
    m_reset();
    for (int p = 0; p < NLOC; p++) look(p, "R8 clear");

    // retrain after clear
    for (int it = 0; it < 30; it++) branch(it % 4, it % 3 == 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule